// File: doc/BRIEF.md
# Programmable YCbCr to RGB Colour-Space Converter

This block turns a stream of YCbCr pixels with 10-bit components into 10-bit RGB. Each output channel is a weighted sum of the three input components, after a per-component offset has been removed from each one. All nine weights and the three offsets are signed register values that software loads through a small write-only register port. Loading a different set is how software selects a colour standard (BT.601, BT.709, BT.2020) and a range (limited or full). The block applies whatever values are loaded and knows nothing about standards. After reset it holds the BT.601 limited-range set.

The register writes go into a shadow bank. A one-cycle frame-start pulse copies the shadow bank into the active bank used by the datapath, so a frame is never converted with a half-loaded set. Software issues the pulse at a frame boundary, when no pixel is inside the pipeline.

Pixels enter and leave on valid/ready handshakes. The pipeline has three register stages and accepts one pixel per cycle while the output is drained. A pixel transfers on a clock edge where both valid and ready are high. While `out_valid` is high and `out_ready` is low, the whole pipeline holds: the output word stays stable and `in_ready` is low. `in_ready` does not depend on `in_valid`.

Top module: `ycc_rgb_csc`

## Requirements
- R1: After reset the active set is the BT.601 limited-range set: row R = 1192, 0, 1634; row G = 1192, -401, -832; row B = 1192, 2066, 0; offsets Y = 64, Cb = 512, Cr = 512. `out_valid` is low and `in_ready` is high.
- R2: Each output equals (wY·(Y−oY) + wCb·(Cb−oCb) + wCr·(Cr−oCr) + 512) shifted arithmetically right by 10 bits, so a weight of 1024 means 1.0 and the result is rounded half up. The weights are the row for that channel.
- R3: When the rounded sum is below 0 the output is 0, and when it is above 1023 the output is 1023.
- R4: Register i (0 to 11) sits at byte address 4·i. Indices 0–2 form row R, 3–5 row G and 6–8 row B, each row in the order Y, Cb, Cr weight. Indices 9, 10 and 11 are the Y, Cb and Cr offsets. A weight takes all 14 data bits as two's complement. An offset takes only data bits 9:0, read as unsigned.
- R5: A write to an address whose bits 1:0 are not zero, or whose index is 12 or above, changes no register.
- R6: Writes change only the shadow bank and have no effect on the conversion until a frame-start pulse. The pulse copies all twelve shadow values to the active bank. A write in the same cycle as the pulse reaches the shadow bank but is not part of that copy.
- R7: While `out_valid` is high and `out_ready` is low, the output values and `out_valid` stay unchanged in the next cycle, and `in_ready` is low.
- R8: With `out_ready` held high, a pixel accepted on edge k shows on the output from edge k+2 and completes its transfer on edge k+3. The block accepts a pixel every cycle, and pixels leave in the order they arrived, none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register byte address |
| cfg_wdata | input | 14 | Register write data |
| frame_start | input | 1 | Copies the shadow bank into the active bank |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_y | input | 10 | Luma component |
| in_cb | input | 10 | Blue-difference chroma |
| in_cr | input | 10 | Red-difference chroma |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can accept a pixel |
| out_r | output | 10 | Red result |
| out_g | output | 10 | Green result |
| out_b | output | 10 | Blue result |

## Verification
A wrong weight or offset in the active bank shows up in the first pixel converted after it is committed, three edges after acceptance. Without a commit, a shadow bank that leaked into the active set would show on the very next pixel. A wrong stage enable shows up as a changed output word during a stall, a duplicated or dropped pixel, or a transfer one cycle off the expected latency. The bench compares every output transfer against a behavioural model, so each of these faults appears within a few cycles of the event that caused it.

// File: rtl/csc_pkg.sv
package csc_pkg;

  // Number of programmable terms: nine weights then three offsets.
  localparam int NUM_WEIGHTS = 9;
  localparam int NUM_OFFSETS = 3;
  localparam int NUM_TERMS   = NUM_WEIGHTS + NUM_OFFSETS;

  // Reset value of term idx: BT.601 limited range.
  function automatic int csc_reset_term(int idx);
    case (idx)
      0:  return 1192;
      1:  return 0;
      2:  return 1634;
      3:  return 1192;
      4:  return -401;
      5:  return -832;
      6:  return 1192;
      7:  return 2066;
      8:  return 0;
      9:  return 64;
      10: return 512;
      11: return 512;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank #(
  parameter int COEF_W = 14,
  parameter int OFS_W  = 10,
  parameter int ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [COEF_W-1:0]        cfg_wdata,
  input  logic                     frame_start,
  output logic signed [COEF_W-1:0] act_w   [csc_pkg::NUM_WEIGHTS],
  output logic [OFS_W-1:0]         act_ofs [csc_pkg::NUM_OFFSETS]
);
  import csc_pkg::*;

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TERMS - 1);

  logic [IDX_W-1:0] wr_idx;
  logic             wr_hit;

  assign wr_idx = cfg_addr[ADDR_W-1:2];
  assign wr_hit = cfg_we && (cfg_addr[1:0] == 2'b00) && (wr_idx <= LAST_IDX);

  logic signed [COEF_W-1:0] shd_w   [NUM_WEIGHTS];
  logic [OFS_W-1:0]         shd_ofs [NUM_OFFSETS];

  for (genvar i = 0; i < NUM_WEIGHTS; i++) begin : g_weight
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_w[i] <= COEF_W'(csc_reset_term(i));
        act_w[i] <= COEF_W'(csc_reset_term(i));
      end else begin
        if (wr_hit && (wr_idx == IDX_W'(i))) shd_w[i] <= cfg_wdata;
        if (frame_start) act_w[i] <= shd_w[i];
      end
    end

    a_r4_weight_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && (wr_idx == IDX_W'(i))) |=> (shd_w[i] == $past(cfg_wdata)));
    a_r6_weight_commit: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (act_w[i] == $past(shd_w[i])));
    a_r6_weight_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(act_w[i]));
  end

  for (genvar j = 0; j < NUM_OFFSETS; j++) begin : g_offset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_ofs[j] <= OFS_W'(csc_reset_term(NUM_WEIGHTS + j));
        act_ofs[j] <= OFS_W'(csc_reset_term(NUM_WEIGHTS + j));
      end else begin
        if (wr_hit && (wr_idx == IDX_W'(NUM_WEIGHTS + j)))
          shd_ofs[j] <= cfg_wdata[OFS_W-1:0];
        if (frame_start) act_ofs[j] <= shd_ofs[j];
      end
    end

    a_r6_offset_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(act_ofs[j]));
    a_r4_offset_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && (wr_idx == IDX_W'(NUM_WEIGHTS + j))) |=>
        (shd_ofs[j] == $past(cfg_wdata[OFS_W-1:0])));
  end

endmodule

// File: rtl/csc_channel.sv
module csc_channel #(
  parameter int COMP_W = 10,
  parameter int COEF_W = 14,
  parameter int FRAC   = 10,
  parameter int DIFF_W = COMP_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic signed [DIFF_W-1:0] d_y,
  input  logic signed [DIFF_W-1:0] d_cb,
  input  logic signed [DIFF_W-1:0] d_cr,
  input  logic signed [COEF_W-1:0] w_y,
  input  logic signed [COEF_W-1:0] w_cb,
  input  logic signed [COEF_W-1:0] w_cr,
  output logic [COMP_W-1:0]        res
);
  localparam int PROD_W = DIFF_W + COEF_W;
  localparam int SUM_W  = PROD_W + 2;
  localparam int HALF   = 1 << (FRAC - 1);
  localparam int MAXV   = (1 << COMP_W) - 1;

  // Stage 2: three products.
  logic signed [PROD_W-1:0] p_y, p_cb, p_cr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_y  <= '0;
      p_cb <= '0;
      p_cr <= '0;
    end else if (adv) begin
      p_y  <= PROD_W'(d_y)  * PROD_W'(w_y);
      p_cb <= PROD_W'(d_cb) * PROD_W'(w_cb);
      p_cr <= PROD_W'(d_cr) * PROD_W'(w_cr);
    end
  end

  // Stage 3: sum, round, scale, clamp.
  logic signed [SUM_W-1:0] acc, scaled;
  logic [COMP_W-1:0]       sat;

  always_comb begin
    acc    = SUM_W'(p_y) + SUM_W'(p_cb) + SUM_W'(p_cr) + SUM_W'(HALF);
    scaled = acc >>> FRAC;
    if (scaled < SUM_W'(0))
      sat = '0;
    else if (scaled > SUM_W'(MAXV))
      sat = COMP_W'(MAXV);
    else
      sat = scaled[COMP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res <= '0;
    else if (adv) res <= sat;
  end

  a_r3_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (scaled < SUM_W'(0))) |=> (res == '0));
  a_r3_ceiling_max: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (scaled > SUM_W'(MAXV))) |=> (res == COMP_W'(MAXV)));

endmodule

// File: rtl/ycc_rgb_csc.sv
module ycc_rgb_csc #(
  parameter int COMP_W = 10,
  parameter int COEF_W = 14,
  parameter int OFS_W  = 10,
  parameter int FRAC   = 10,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [COEF_W-1:0] cfg_wdata,
  input  logic              frame_start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [COMP_W-1:0] in_y,
  input  logic [COMP_W-1:0] in_cb,
  input  logic [COMP_W-1:0] in_cr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [COMP_W-1:0] out_r,
  output logic [COMP_W-1:0] out_g,
  output logic [COMP_W-1:0] out_b
);
  import csc_pkg::*;

  localparam int DIFF_W = COMP_W + 1;
  localparam int NUM_CH = 3;

  logic signed [COEF_W-1:0] act_w   [NUM_WEIGHTS];
  logic [OFS_W-1:0]         act_ofs [NUM_OFFSETS];

  csc_coef_bank #(
    .COEF_W (COEF_W),
    .OFS_W  (OFS_W),
    .ADDR_W (ADDR_W)
  ) i_coef_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .frame_start (frame_start),
    .act_w       (act_w),
    .act_ofs     (act_ofs)
  );

  // Global stage enable: every stage moves when the last one can drain.
  logic adv;
  logic v1, v2, v3;

  assign adv       = !v3 || out_ready;
  assign in_ready  = adv;
  assign out_valid = v3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  // Stage 1: remove offsets.
  logic signed [DIFF_W-1:0] d_y, d_cb, d_cr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_y  <= '0;
      d_cb <= '0;
      d_cr <= '0;
    end else if (adv) begin
      d_y  <= DIFF_W'($signed({1'b0, in_y}))  - DIFF_W'($signed({1'b0, act_ofs[0]}));
      d_cb <= DIFF_W'($signed({1'b0, in_cb})) - DIFF_W'($signed({1'b0, act_ofs[1]}));
      d_cr <= DIFF_W'($signed({1'b0, in_cr})) - DIFF_W'($signed({1'b0, act_ofs[2]}));
    end
  end

  // Stages 2 and 3: one channel per output colour.
  logic [COMP_W-1:0] ch_res [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    csc_channel #(
      .COMP_W (COMP_W),
      .COEF_W (COEF_W),
      .FRAC   (FRAC),
      .DIFF_W (DIFF_W)
    ) i_channel (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .d_y   (d_y),
      .d_cb  (d_cb),
      .d_cr  (d_cr),
      .w_y   (act_w[3*c]),
      .w_cb  (act_w[3*c+1]),
      .w_cr  (act_w[3*c+2]),
      .res   (ch_res[c])
    );
  end

  assign out_r = ch_res[0];
  assign out_g = ch_res[1];
  assign out_b = ch_res[2];

  a_r7_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));
  a_r7_block_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  a_r8_fill_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_ready) |=> v1);

endmodule

// File: tb/test_ycc_rgb_csc.sv
module test_ycc_rgb_csc;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [13:0] cfg_wdata = '0;
  logic       frame_start = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_y = '0, in_cb = '0, in_cr = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [9:0] out_r, out_g, out_b;

  always #2 clk = ~clk;

  ycc_rgb_csc i_ycc_rgb_csc (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .frame_start,
    .in_valid, .in_ready, .in_y, .in_cb, .in_cr,
    .out_valid, .out_ready, .out_r, .out_g, .out_b
  );

  typedef struct { int r; int g; int b; int cyc; } exp_t;
  exp_t q[$];

  int sh[12];
  int ac[12];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit lat_mode = 0;
  bit rdy_rand = 0;
  bit accepted = 0;
  bit was_stall = 0;
  int prev_r, prev_g, prev_b;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int conv(int ch, int y, int cb, int cr);
    int s;
    s = ac[3*ch] * (y - (ac[9] & 1023)) + ac[3*ch+1] * (cb - (ac[10] & 1023))
      + ac[3*ch+2] * (cr - (ac[11] & 1023)) + 512;
    s = s >>> 10;
    if (s < 0) s = 0;
    if (s > 1023) s = 1023;
    return s;
  endfunction

  // Evaluate the coming edge 1 ns before it, then advance to the next negedge.
  task automatic step();
    exp_t e;
    if (rdy_rand) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[3];
    end
    #1;
    cyc++;
    accepted = 0;
    if (was_stall) begin
      chk(out_valid === 1'b1, "R7 valid held", out_valid, 1);
      chk(out_r == prev_r && out_g == prev_g && out_b == prev_b, "R7 data held", out_r, prev_r);
    end
    if (out_valid && !out_ready)
      chk(in_ready === 1'b0, "R7 input blocked", in_ready, 0);
    if (out_valid) begin
      chk(q.size() > 0, "R8 no spurious output", 0, 1);
      if (out_ready && q.size() > 0) begin
        e = q.pop_front();
        chk(out_r == e.r, "R2 red", out_r, e.r);
        chk(out_g == e.g, "R2 green", out_g, e.g);
        chk(out_b == e.b, "R2 blue", out_b, e.b);
        if (lat_mode) chk(cyc - e.cyc == 3, "R8 latency", cyc - e.cyc, 3);
      end
    end
    was_stall = out_valid && !out_ready;
    prev_r = out_r; prev_g = out_g; prev_b = out_b;
    if (in_valid && in_ready) begin
      accepted = 1;
      e.r = conv(0, in_y, in_cb, in_cr);
      e.g = conv(1, in_y, in_cb, in_cr);
      e.b = conv(2, in_y, in_cb, in_cr);
      e.cyc = cyc;
      q.push_back(e);
    end
    if (frame_start) for (int i = 0; i < 12; i++) ac[i] = sh[i];
    if (cfg_we && cfg_addr[1:0] == 2'b00 && (cfg_addr >> 2) < 12)
      sh[cfg_addr >> 2] = $signed(cfg_wdata);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(int y, int cb, int cr);
    in_valid = 1; in_y = 10'(y); in_cb = 10'(cb); in_cr = 10'(cr);
    do step(); while (!accepted);
    in_valid = 0;
  endtask

  task automatic drain();
    bit keep;
    keep = rdy_rand;
    rdy_rand = 0; out_ready = 1; in_valid = 0;
    for (int k = 0; k < 8; k++) step();
    rdy_rand = keep;
    chk(q.size() == 0, "R8 all delivered", q.size(), 0);
  endtask

  task automatic wr(int addr, int val);
    cfg_we = 1; cfg_addr = 6'(addr); cfg_wdata = 14'(val);
    step();
    cfg_we = 0;
  endtask

  task automatic commit();
    drain();
    frame_start = 1; step(); frame_start = 0;
  endtask

  task automatic load_set(int a0, int a1, int a2, int a3, int a4, int a5,
                          int a6, int a7, int a8, int o0, int o1, int o2);
    int v[12];
    v = '{a0, a1, a2, a3, a4, a5, a6, a7, a8, o0, o1, o2};
    for (int i = 0; i < 12; i++) wr(4*i, v[i]);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog R8 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // Model reset state: BT.601 limited (R1).
    sh = '{1192, 0, 1634, 1192, -401, -832, 1192, 2066, 0, 64, 512, 512};
    ac = sh;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(in_ready === 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(out_valid === 1'b0, "R1 out_valid after reset", out_valid, 0);
    @(negedge clk);

    // R1/R2: reset set applied to several patterns.
    send(64, 512, 512);
    send(940, 512, 512);
    send(500, 300, 700);
    send(235, 800, 100);
    drain();

    // R6: BT.709 full range loaded into shadow only; R2 results stay BT.601.
    load_set(1024, 0, 1613, 1024, -192, -479, 1024, 1900, 0, 0, 512, 512);
    send(700, 400, 650);
    send(100, 900, 200);
    commit();
    send(700, 400, 650);
    send(100, 900, 200);
    send(1023, 512, 512);
    drain();

    // R6: write in the same cycle as the pulse misses that copy.
    cfg_we = 1; cfg_addr = 6'd0; cfg_wdata = 14'(800); frame_start = 1;
    step();
    cfg_we = 0; frame_start = 0;
    send(600, 512, 512);
    commit();
    send(600, 512, 512);
    drain();

    // R5: misaligned and out-of-range writes are dropped.
    wr(1, 3000);
    wr(4*12, 3000);
    wr(4*15 + 2, 3000);
    commit();
    send(600, 300, 700);
    drain();

    // R4: BT.709 limited, offset written with bits above 9 set.
    load_set(1192, 0, 1836, 1192, -218, -546, 1192, 2163, 0, 1024 + 64, 512, 512);
    commit();
    send(64, 512, 512);
    send(900, 200, 800);
    drain();

    // R3: clamp at both ends with the BT.601 limited set.
    load_set(1192, 0, 1634, 1192, -401, -832, 1192, 2066, 0, 64, 512, 512);
    commit();
    send(1023, 1023, 1023);
    send(0, 0, 0);
    send(1023, 1023, 0);
    send(0, 1023, 1023);
    drain();

    // R8: back-to-back stream with ready held high.
    lat_mode = 1;
    for (int k = 0; k < 10; k++) begin
      in_valid = 1; in_y = 10'(k * 97); in_cb = 10'(1023 - k * 61); in_cr = 10'(k * 113);
      step();
      chk(accepted, "R8 one pixel per cycle", accepted, 1);
    end
    in_valid = 0;
    drain();
    lat_mode = 0;

    // R7: random back-pressure and gaps.
    rdy_rand = 1;
    for (int k = 0; k < 60; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2]) send(lfsr[9:0], lfsr[15:6], {lfsr[4:0], lfsr[15:11]});
      else step();
    end
    rdy_rand = 0;
    drain();

    finish_run();
  end

endmodule